// File: doc/BRIEF.md
# Carrier-Ripple Envelope Ratio Demodulator

This block turns switching ripple in a magnetic-bearing coil into a rotor-position estimate. It takes two streams of signed samples, coil current and coil voltage. Both streams have already been band-pass filtered around the switching carrier. Each stream is full-wave rectified and smoothed by a first-order low-pass filter, which leaves the ripple envelope. Both channels use the same filter.

Once per carrier period (every 50 accepted samples) the block divides the current envelope by the voltage envelope. Taking the ratio cancels the effect of the amplifier duty cycle. A sequential divider produces the quotient as an unscaled fixed-point value with a one-cycle strobe. Scaling, linearisation and the position loop sit downstream.

Top module: `env_ratio_demod`

## Requirements
- R1: After synchronous reset, `pos_valid`, `pos_q` and `div_err` are all zero and both envelopes are zero.
- R2: Rectification gives the magnitude of the 16-bit two's complement sample. The most negative code, -32768, maps to 32767.
- R3: On each cycle with `smp_valid` high, each envelope y (24 bits, 8 fraction bits) updates as y <= y + ((mag*256 - y) >>> 6). The shift is arithmetic and rounds toward minus infinity. Samples presented with `smp_valid` low change nothing.
- R4: Both channels are filtered identically, so identical current and voltage streams give a quotient of exactly 256 (1.0).
- R5: A division request is raised once every 50 samples with `smp_valid` high. The count is of valid samples, not cycles.
- R6: The result is floor(i_env*256 / v_env), given on `pos_q` as unsigned Q8.8. It uses both envelopes as they stand after the 50th sample.
- R7: A quotient above 65535 with a nonzero voltage envelope gives `pos_q` = 0xFFFF and `div_err` = 0.
- R8: A voltage envelope of zero gives `pos_q` = 0xFFFF and `div_err` = 1. `pos_q` and `div_err` hold their values until the next strobe.
- R9: `pos_valid` is a one-cycle pulse. If the 50th sample is presented in cycle t, the pulse appears in cycle t+34.
- R10: A request that arrives while the divider is busy is dropped, with no queueing. This includes a request in the cycle the divider finishes. The divider accepts again from the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe for both channels |
| cur_smp | input | 16 | Band-passed coil current sample, signed |
| vlt_smp | input | 16 | Band-passed coil voltage sample, signed |
| pos_valid | output | 1 | One-cycle strobe for a new quotient |
| pos_q | output | 16 | Envelope ratio, unsigned Q8.8 |
| div_err | output | 1 | Quotient came from a zero voltage envelope |

## Verification
Two functions can fall in the same cycle: a decimation request and the last iteration of the divider. A second instance with a decimation of 8 is fed back-to-back samples, so its fifth request lands exactly on the divider's finishing edge. The bench keeps its own model of when the divider is free. It expects that request to be dropped and the next accepted one to carry the envelopes of sample 48. A wrong strobe count, a wrong value or a wrong strobe cycle all count as failures.

// File: rtl/env_pkg.sv
package env_pkg;
  // channel slots in the per-channel arrays of the top
  localparam int NCH    = 2;
  localparam int CH_CUR = 0;
  localparam int CH_VLT = 1;

  typedef enum logic [0:0] {DIV_IDLE = 1'b0, DIV_RUN = 1'b1} div_state_e;
endpackage

// File: rtl/env_rectify.sv
module env_rectify #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] x,
  output logic        [DW-2:0] mag
);
  localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] neg;

  always_comb begin
    neg = -x;
    if (x == MOST_NEG)  mag = '1;            // saturate the one unrepresentable magnitude
    else if (x[DW-1])   mag = neg[DW-2:0];
    else                mag = x[DW-2:0];
  end
endmodule

// File: rtl/env_lpf.sv
module env_lpf #(
  parameter int DW    = 16,
  parameter int EW    = 24,
  parameter int FRAC  = 8,
  parameter int SHIFT = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  output logic        [EW-1:0] y
);
  localparam int MW  = DW - 1;          // magnitude width
  localparam int TW  = EW + 1;          // signed working width
  localparam int PAD = TW - MW - FRAC;  // must stay positive

  logic        [MW-1:0] mag;
  logic signed [TW-1:0] tgt, cur, diff, step;

  env_rectify #(.DW(DW)) u_rect (.x(x), .mag(mag));

  always_comb begin
    tgt  = $signed({{PAD{1'b0}}, mag, {FRAC{1'b0}}});
    cur  = $signed({1'b0, y});
    diff = tgt - cur;
    step = diff >>> SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst)     y <= '0;
    else if (en) y <= y + step[EW-1:0];
  end
endmodule

// File: rtl/env_divider.sv
module env_divider
  import env_pkg::*;
#(
  parameter int NW   = 32,   // dividend width
  parameter int DENW = 24,   // divisor width
  parameter int QW   = 16    // output width, saturated
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NW-1:0]   num,
  input  logic [DENW-1:0] den,
  output logic            busy,
  output logic            done,
  output logic [QW-1:0]   quo,
  output logic            zero_err
);
  localparam int CW = $clog2(NW + 1);

  div_state_e      state;
  logic [CW-1:0]   cnt;
  logic [DENW:0]   rem, rem_sh, rem_nx;
  logic [NW-1:0]   acc, acc_nx;
  logic [DENW-1:0] den_r;
  logic            zero_r, ge;

  assign busy = (state == DIV_RUN);

  always_comb begin
    rem_sh = {rem[DENW-1:0], acc[NW-1]};
    ge     = rem_sh >= {1'b0, den_r};
    rem_nx = ge ? (rem_sh - {1'b0, den_r}) : rem_sh;
    acc_nx = {acc[NW-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= DIV_IDLE;
      cnt      <= '0;
      rem      <= '0;
      acc      <= '0;
      den_r    <= '0;
      zero_r   <= 1'b0;
      done     <= 1'b0;
      quo      <= '0;
      zero_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        DIV_IDLE: if (start) begin
          acc    <= num;
          den_r  <= den;
          rem    <= '0;
          cnt    <= CW'(NW);
          zero_r <= (den == '0);
          state  <= DIV_RUN;
        end
        DIV_RUN: begin
          rem <= rem_nx;
          acc <= acc_nx;
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            state    <= DIV_IDLE;
            done     <= 1'b1;
            quo      <= (acc_nx[NW-1:QW] != '0) ? '1 : acc_nx[QW-1:0];
            zero_err <= zero_r;
          end
        end
        default: state <= DIV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/env_ratio_demod.sv
module env_ratio_demod
  import env_pkg::*;
#(
  parameter int DW    = 16,
  parameter int EW    = 24,
  parameter int FRAC  = 8,
  parameter int SHIFT = 6,
  parameter int QFRAC = 8,
  parameter int QW    = 16,
  parameter int DEC   = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] cur_smp,
  input  logic [DW-1:0] vlt_smp,
  output logic          pos_valid,
  output logic [QW-1:0] pos_q,
  output logic          div_err
);
  localparam int NW   = EW + QFRAC;
  localparam int CNTW = (DEC > 1) ? $clog2(DEC) : 1;

  logic signed [DW-1:0] smp_arr [NCH];
  logic        [EW-1:0] env_arr [NCH];
  logic [EW-1:0]        i_env, v_env;
  logic [CNTW-1:0]      dec_cnt;
  logic                 dec_tick;
  logic                 div_busy;

  assign smp_arr[CH_CUR] = $signed(cur_smp);
  assign smp_arr[CH_VLT] = $signed(vlt_smp);

  // identical envelope paths, advanced in lockstep by the shared strobe
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    env_lpf #(.DW(DW), .EW(EW), .FRAC(FRAC), .SHIFT(SHIFT)) u_lpf (
      .clk (clk),
      .rst (rst),
      .en  (smp_valid),
      .x   (smp_arr[ch]),
      .y   (env_arr[ch])
    );
  end

  assign i_env = env_arr[CH_CUR];
  assign v_env = env_arr[CH_VLT];

  // decimation: one request per DEC accepted samples, raised after the envelopes update
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_cnt  <= '0;
      dec_tick <= 1'b0;
    end else begin
      dec_tick <= smp_valid && (dec_cnt == CNTW'(DEC - 1));
      if (smp_valid) dec_cnt <= (dec_cnt == CNTW'(DEC - 1)) ? '0 : dec_cnt + 1'b1;
    end
  end

  env_divider #(.NW(NW), .DENW(EW), .QW(QW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (dec_tick),
    .num      ({i_env, {QFRAC{1'b0}}}),
    .den      (v_env),
    .busy     (div_busy),
    .done     (pos_valid),
    .quo      (pos_q),
    .zero_err (div_err)
  );
endmodule

// File: rtl/env_ratio_chk.sv
module env_ratio_chk #(
  parameter int EW = 24,
  parameter int QW = 16,
  parameter int DW = 16,
  parameter int FRAC = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic          pos_valid,
  input logic [QW-1:0] pos_q,
  input logic          div_err,
  input logic          busy,
  input logic          tick,
  input logic [EW-1:0] ienv,
  input logic [EW-1:0] venv
);
  localparam logic [EW-1:0] ENV_MAX = EW'(((1 << (DW - 1)) - 1) << FRAC);

  // R3
  env_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (ienv <= ENV_MAX) && (venv <= ENV_MAX));

  // R5
  tick_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(smp_valid));

  // R10
  load_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tick));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    pos_valid |=> !pos_valid);

  // R9
  strobe_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pos_valid |-> $past(busy));

  // R8
  err_saturates_chk: assert property (@(posedge clk) disable iff (rst)
    (pos_valid && div_err) |-> (pos_q == '1));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pos_valid |-> ($stable(pos_q) && $stable(div_err)));
endmodule

bind env_ratio_demod env_ratio_chk #(.EW(EW), .QW(QW), .DW(DW), .FRAC(FRAC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .pos_valid (pos_valid),
  .pos_q     (pos_q),
  .div_err   (div_err),
  .busy      (div_busy),
  .tick      (dec_tick),
  .ienv      (i_env),
  .venv      (v_env)
);

// File: tb/tb_env_ratio_demod.sv
`timescale 1ns/1ps
module tb_env_ratio_demod;
  localparam int DIV_W = 32;
  localparam int DEC0  = 50;
  localparam int DEC1  = 8;
  localparam int SLOTS = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] cur_smp = '0;
  logic [15:0] vlt_smp = '0;
  logic        pv0, pv1, e0, e1;
  logic [15:0] q0, q1;

  env_ratio_demod dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .cur_smp(cur_smp), .vlt_smp(vlt_smp),
    .pos_valid(pv0), .pos_q(q0), .div_err(e0));

  env_ratio_demod #(.DEC(DEC1)) dut2 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .cur_smp(cur_smp), .vlt_smp(vlt_smp),
    .pos_valid(pv1), .pos_q(q1), .div_err(e1));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0, errors = 0;
  bit    done_flag = 0;
  string phase = "R1";
  int    mi = 0, mv = 0, seg_valid = 0, exp_total0 = 0;
  int    dcnt [2], free_edge [2], wr [2], rd [2], n_seen [2];
  int    exp_q [2][SLOTS];
  bit    exp_e [2][SLOTS];
  bit    exp_same [2][SLOTS];
  int    exp_due [2][SLOTS];
  int    last_q [2];
  bit    last_e [2];

  function automatic int lpf_step(int y, int x);
    int mag, d;
    mag = (x < 0) ? ((x == -32768) ? 32767 : -x) : x;
    d   = (mag <<< 8) - y;
    return y + (d >>> 6);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic push(int k, int load_edge);
    longint n, qq;
    n = longint'(mi) * 256;
    if (mv == 0) begin
      exp_q[k][wr[k]] = 65535; exp_e[k][wr[k]] = 1'b1;
    end else begin
      qq = n / longint'(mv);
      exp_q[k][wr[k]] = (qq > 65535) ? 65535 : int'(qq);
      exp_e[k][wr[k]] = 1'b0;
    end
    exp_same[k][wr[k]] = (phase == "R4");
    exp_due[k][wr[k]]  = load_edge + DIV_W;
    wr[k]++;
  endtask

  task automatic drive(bit v, int c, int vv);
    int lim, ld;
    @(negedge clk);
    smp_valid = v;
    cur_smp   = c[15:0];
    vlt_smp   = vv[15:0];
    if (v) begin
      mi = lpf_step(mi, c);
      mv = lpf_step(mv, vv);
      seg_valid++;
      for (int k = 0; k < 2; k++) begin
        lim = (k == 0) ? DEC0 : DEC1;
        dcnt[k]++;
        if (dcnt[k] == lim) begin
          dcnt[k] = 0;
          ld = cyc + 2;               // sample edge, request edge, load edge
          if (ld >= free_edge[k]) begin
            push(k, ld);
            free_edge[k] = ld + DIV_W + 1;
          end
        end
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    exp_total0 += seg_valid / DEC0;
    check(rd[0] == wr[0], "R5", "results drained before reset", rd[0], wr[0]);
    repeat (4) @(negedge clk);
    mi = 0; mv = 0; seg_valid = 0;
    for (int k = 0; k < 2; k++) begin
      dcnt[k] = 0; free_edge[k] = 0; wr[k] = 0; rd[k] = 0; last_q[k] = 0; last_e[k] = 0;
    end
    rst = 1'b0;
    @(negedge clk);
    check(pv0 == 0 && q0 == 0 && e0 == 0, "R1", "reset state dut", int'(q0), 0);
    check(pv1 == 0 && q1 == 0 && e1 == 0, "R1", "reset state dut2", int'(q1), 0);
  endtask

  task automatic mon(int k, bit pv, int qv, bit ev);
    string tag;
    if (rd[k] < wr[k] && exp_due[k][rd[k]] == cyc) begin
      if (k == 1)                  tag = "R10";
      else if (exp_e[k][rd[k]])    tag = "R8";
      else if (exp_q[k][rd[k]] == 65535) tag = "R7";
      else                         tag = "R6";
      check(pv, "R9", "strobe in expected cycle", pv, 1);
      check(qv == exp_q[k][rd[k]], tag, "quotient", qv, exp_q[k][rd[k]]);
      check(ev == exp_e[k][rd[k]], tag, "error flag", ev, exp_e[k][rd[k]]);
      if (exp_same[k][rd[k]] && !exp_e[k][rd[k]])
        check(qv == 256, "R4", "identical channels give unity", qv, 256);
      last_q[k] = exp_q[k][rd[k]];
      last_e[k] = exp_e[k][rd[k]];
      rd[k]++;
      n_seen[k]++;
    end else begin
      if (pv) check(1'b0, (k == 1) ? "R10" : "R9", "unexpected strobe", 1, 0);
      check(qv == last_q[k] && ev == last_e[k], "R8", "output held between strobes", qv, last_q[k]);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      mon(0, pv0, int'(q0), e0);
      mon(1, pv1, int'(q1), e1);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20071));
    for (int k = 0; k < 2; k++) begin
      dcnt[k] = 0; free_edge[k] = 0; wr[k] = 0; rd[k] = 0; n_seen[k] = 0; last_q[k] = 0; last_e[k] = 0;
    end
    repeat (3) @(negedge clk);
    do_reset();                                   // R1

    // R8: zero voltage envelope, back-to-back samples also exercise the dropped requests (R10)
    phase = "R8";
    for (int i = 0; i < 120; i++) drive(1'b1, int'($urandom_range(60000)) - 30000, 0);
    idle(60);

    do_reset();
    // R4 / R3: identical streams with gaps carrying unrelated data
    phase = "R4";
    for (int i = 0; i < 400; i++) begin
      int s = int'($urandom_range(64000)) - 32000;
      if ($urandom_range(3) == 0) drive(1'b0, s, -s / 3 + 7);
      else                        drive(1'b1, s, s);
    end
    idle(60);

    // R6: unrelated random channels
    phase = "R6";
    for (int i = 0; i < 1000; i++)
      drive($urandom_range(9) != 0, int'($urandom_range(40000)) - 20000, int'($urandom_range(60000)) - 30000);

    // R2: most negative current code against a small voltage
    phase = "R2";
    for (int i = 0; i < 600; i++) drive(1'b1, -32768, 128);

    // R7: large current, unit voltage, quotient overflows
    phase = "R7";
    for (int i = 0; i < 500; i++) drive(1'b1, ($urandom_range(1) != 0) ? 30000 : -30000, ($urandom_range(1) != 0) ? 1 : -1);
    idle(60);

    exp_total0 += seg_valid / DEC0;
    @(negedge clk);
    check(n_seen[0] == exp_total0, "R5", "one result per 50 valid samples", n_seen[0], exp_total0);
    check(rd[1] == wr[1], "R10", "busy instance results all seen", rd[1], wr[1]);
    check(n_seen[1] < exp_total0 * (DEC0 / DEC1), "R10", "requests dropped while busy", n_seen[1], exp_total0 * (DEC0 / DEC1));
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule